// File: doc/BRIEF.md
# Reseeding Pattern Generator

This block is an on-chip test stimulus source for a small sequential circuit under test. A 12-bit shift register is filled from a table of seeds fixed at elaboration. Each seed passes through two phases. In the advance phase the register steps through a maximal-length feedback sequence for a programmable number of cycles. In the rotate phase the feedback is gated off, and the register is rotated right once per cycle for eleven cycles. This yields further patterns without advancing the sequence. A seed of all zeros is skipped, because it would lock the register at zero.

A few fixed gates turn every valid 12-bit pattern into a 4-bit primary-input vector. A response checker compares the output of the circuit under test against the fault-free output while a pattern is valid. The first difference raises a flag that stays set. A start pulse restarts the seed walk from the first table entry and clears the flag. A done indication holds after the last seed has been used.

Top module: `rsd_pattern_gen`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `pat_valid`, `lfsr_active`, `done` and `mismatch` are all 0.
- R2: A start pulse sets the seed index to entry 0, which occupies bits [11:0] of the table. In the cycle after the start edge the unit checks the seed at the current index. A nonzero seed is loaded into the register. A zero seed uses that cycle, is never loaded, and the index moves on. The seed 12'hA64 is accepted and is the first pattern shown.
- R3: In the advance phase the pattern shown in the next cycle is {s[10:0], s[11]^s[5]^s[3]^s[0]}, where s is the current pattern. The phase lasts exactly `step_count` cycles per seed, and `lfsr_active` is 1 in precisely those cycles.
- R4: The rotate phase lasts exactly 11 cycles. Its first pattern is the value left by the advance phase. Each following pattern is the previous one rotated right, {s[0], s[11:1]}.
- R5: `pat_valid` is 1 in the advance and rotate phases only. The cycle in which a seed is loaded has `pat_valid` at 0, and a valid pattern is never zero.
- R6: `pat_vec[0]` is the OR of pattern bits 0 and 1. `pat_vec[1]` equals pattern bit 3.
- R7: `pat_vec[2]` is the AND of pattern bits 6 and 7. `pat_vec[3]` equals pattern bit 9.
- R8: After the rotate phase of the last table entry, or after a zero last entry is skipped, `done` becomes 1. It stays 1 until a start pulse, and a start pulse in any phase restarts the walk.
- R9: `mismatch` becomes 1 in the cycle after a cycle with `pat_valid` = 1 and `cut_resp` != `gold_resp`. It then stays 1 until reset or a start pulse, and a start edge clears it. A difference while `pat_valid` is 0 has no effect.
- R10: With `step_count` = 0, a loaded seed goes straight into the rotate phase, and the seed itself is the first rotate pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart of the seed walk; clears the mismatch flag |
| step_count | input | STEP_W | Number of advance cycles per seed |
| cut_resp | input | RESP_W | Response of the circuit under test |
| gold_resp | input | RESP_W | Expected fault-free response |
| pat_state | output | 12 | Current raw 12-bit pattern |
| pat_vec | output | 4 | Shaped primary-input vector |
| pat_valid | output | 1 | Pattern and vector are driven this cycle |
| lfsr_active | output | 1 | Register is advancing by its feedback sequence |
| done | output | 1 | All seeds used |
| mismatch | output | 1 | Sticky response-difference flag |

## Verification
Two events can fall in the same cycle. A start pulse can arrive in a cycle where a response difference is also present. A difference can also occur on the last valid pattern of a seed, as the unit leaves for the next seed load. The bench places start pulses in the middle of runs while it drives random response differences. It also runs a mode where differences appear only in invalid cycles. A cycle-level reference model, built from the requirements, predicts the flag. A start edge must win over a coincident difference, and a difference in a load or done cycle must leave the flag clear.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LOAD = 3'd1,
      PH_RUN  = 3'd2,
      PH_ROT  = 3'd3,
      PH_DONE = 3'd4
   } rpg_phase_e;

   localparam int unsigned RPG_REG_W = 12;
   localparam int unsigned RPG_VEC_W = 4;
endpackage

// File: rtl/rpg_shift_core.sv
module rpg_shift_core #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         adv_en,
   input  logic         rot_en,
   output logic [W-1:0] state_o
);
   logic [W-1:0] state_q;
   logic         fb;

   generate
      if (W != 12) begin : g_bad_w
         $error("rpg_shift_core: feedback taps are defined for a 12-bit register");
      end
   endgenerate

   assign fb = state_q[W-1] ^ state_q[5] ^ state_q[3] ^ state_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state_q <= '0;
      else if (load_en) state_q <= load_val;
      else if (adv_en)  state_q <= {state_q[W-2:0], fb};
      else if (rot_en)  state_q <= {state_q[0], state_q[W-1:1]};
   end

   assign state_o = state_q;

   AST_ROT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      rot_en && !load_en && !adv_en |=> state_o == {$past(state_o[0]), $past(state_o[W-1:1])}); // R4
   AST_ADV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      adv_en && !load_en && state_o != '0 |=> state_o != '0); // R3
endmodule

// File: rtl/rpg_shaper.sv
module rpg_shaper #(
   parameter int unsigned W = 12,
   parameter int unsigned V = 4
) (
   input  logic [W-1:0] state_i,
   output logic [V-1:0] vec_o
);
   logic unused_bits;

   generate
      if (W != 12 || V != 4) begin : g_bad_shape
         $error("rpg_shaper: gate taps need a 12-bit state and 4-bit vector");
      end
   endgenerate

   assign vec_o[0]    = state_i[0] | state_i[1];
   assign vec_o[1]    = state_i[3];
   assign vec_o[2]    = state_i[6] & state_i[7];
   assign vec_o[3]    = state_i[9];
   assign unused_bits = ^{state_i[2], state_i[5:4], state_i[8], state_i[11:10]};
endmodule

// File: rtl/rpg_ctrl.sv
module rpg_ctrl
   import rpg_pkg::*;
#(
   parameter int unsigned W         = 12,
   parameter int unsigned NUM_SEEDS = 4,
   parameter int unsigned STEP_W    = 8,
   parameter logic [NUM_SEEDS*W-1:0] SEED_TABLE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [STEP_W-1:0] step_count,
   output rpg_phase_e        phase_o,
   output logic              load_en,
   output logic [W-1:0]      load_val,
   output logic              adv_en,
   output logic              rot_en
);
   localparam int unsigned IDX_W   = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;
   localparam int unsigned ROT_LEN = W - 1;
   localparam int unsigned RC_W    = $clog2(W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SEEDS - 1);
   localparam logic [RC_W-1:0]  ROT_LAST = RC_W'(ROT_LEN - 1);

   rpg_phase_e        phase_q;
   logic [IDX_W-1:0]  idx_q;
   logic [STEP_W-1:0] run_cnt_q;
   logic [RC_W-1:0]   rot_cnt_q;
   logic [STEP_W:0]   run_nxt;
   logic [W-1:0]      seed_arr [NUM_SEEDS];
   logic [NUM_SEEDS-1:0] seed_nz;
   logic              cur_nz;
   logic              is_last;

   generate
      for (genvar g = 0; g < NUM_SEEDS; g++) begin : g_seed
         assign seed_arr[g] = SEED_TABLE[g*W +: W];
         assign seed_nz[g]  = |SEED_TABLE[g*W +: W];
      end
   endgenerate

   assign cur_nz   = seed_nz[idx_q];
   assign is_last  = (idx_q == LAST_IDX);
   assign run_nxt  = {1'b0, run_cnt_q} + (STEP_W+1)'(1);
   assign load_val = seed_arr[idx_q];
   assign load_en  = (phase_q == PH_LOAD) && cur_nz;
   assign adv_en   = (phase_q == PH_RUN);
   assign rot_en   = (phase_q == PH_ROT);
   assign phase_o  = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         idx_q     <= '0;
         run_cnt_q <= '0;
         rot_cnt_q <= '0;
      end else if (start) begin
         phase_q <= PH_LOAD;
         idx_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_LOAD: begin
               if (!cur_nz) begin
                  if (is_last) phase_q <= PH_DONE;
                  else         idx_q   <= idx_q + IDX_W'(1);
               end else begin
                  run_cnt_q <= '0;
                  rot_cnt_q <= '0;
                  phase_q   <= (step_count == '0) ? PH_ROT : PH_RUN;
               end
            end
            PH_RUN: begin
               run_cnt_q <= run_nxt[STEP_W-1:0];
               if (run_nxt >= {1'b0, step_count}) begin
                  phase_q   <= PH_ROT;
                  rot_cnt_q <= '0;
               end
            end
            PH_ROT: begin
               rot_cnt_q <= rot_cnt_q + RC_W'(1);
               if (rot_cnt_q == ROT_LAST) begin
                  if (is_last) phase_q <= PH_DONE;
                  else begin
                     phase_q <= PH_LOAD;
                     idx_q   <= idx_q + IDX_W'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_en, adv_en, rot_en})); // R5
   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> load_val != '0); // R2
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_DONE && !start |=> phase_q == PH_DONE); // R8
   AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> phase_q == PH_LOAD && idx_q == '0); // R2
endmodule

// File: rtl/rpg_resp_cmp.sv
module rpg_resp_cmp #(
   parameter int unsigned RESP_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              valid,
   input  logic [RESP_W-1:0] act,
   input  logic [RESP_W-1:0] exp_r,
   output logic              flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flag_q <= 1'b0;
      else if (clear)                 flag_q <= 1'b0;
      else if (valid && act != exp_r) flag_q <= 1'b1;
   end

   assign flag = flag_q;

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clear |=> flag); // R9
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !flag); // R9
   AST_IGNORE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !valid && !flag |=> !flag); // R9
endmodule

// File: rtl/rsd_pattern_gen.sv
module rsd_pattern_gen
   import rpg_pkg::*;
#(
   parameter int unsigned NUM_SEEDS = 4,
   parameter int unsigned STEP_W    = 8,
   parameter int unsigned RESP_W    = 1,
   parameter logic [NUM_SEEDS*RPG_REG_W-1:0] SEED_TABLE =
      {12'h3B7, 12'h5C3, 12'h0F1, 12'hA64}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [STEP_W-1:0]    step_count,
   input  logic [RESP_W-1:0]    cut_resp,
   input  logic [RESP_W-1:0]    gold_resp,
   output logic [RPG_REG_W-1:0] pat_state,
   output logic [RPG_VEC_W-1:0] pat_vec,
   output logic                 pat_valid,
   output logic                 lfsr_active,
   output logic                 done,
   output logic                 mismatch
);
   localparam int unsigned W = RPG_REG_W;

   generate
      if (NUM_SEEDS < 1) begin : g_bad_seeds
         $error("rsd_pattern_gen: NUM_SEEDS must be at least 1");
      end
      if (STEP_W < 1 || RESP_W < 1) begin : g_bad_width
         $error("rsd_pattern_gen: STEP_W and RESP_W must be positive");
      end
   endgenerate

   rpg_phase_e   phase;
   logic         load_en, adv_en, rot_en;
   logic [W-1:0] load_val;
   logic [W-1:0] state;

   rpg_ctrl #(
      .W(W), .NUM_SEEDS(NUM_SEEDS), .STEP_W(STEP_W), .SEED_TABLE(SEED_TABLE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .step_count(step_count),
      .phase_o(phase), .load_en(load_en), .load_val(load_val),
      .adv_en(adv_en), .rot_en(rot_en)
   );

   rpg_shift_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
      .adv_en(adv_en), .rot_en(rot_en), .state_o(state)
   );

   rpg_shaper #(.W(W), .V(RPG_VEC_W)) u_shape (
      .state_i(state), .vec_o(pat_vec)
   );

   rpg_resp_cmp #(.RESP_W(RESP_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clear(start), .valid(pat_valid),
      .act(cut_resp), .exp_r(gold_resp), .flag(mismatch)
   );

   assign pat_state   = state;
   assign pat_valid   = (phase == PH_RUN) || (phase == PH_ROT);
   assign lfsr_active = (phase == PH_RUN);
   assign done        = (phase == PH_DONE);

   AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid |-> pat_state != '0); // R5
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !pat_valid && !lfsr_active); // R8
endmodule

// File: tb/sim_rsd_pattern_gen.sv
`timescale 1ns/1ps
module sim_rsd_pattern_gen;
   localparam int NS   = 5;
   localparam int SW   = 6;
   localparam int RW   = 2;
   localparam logic [NS*12-1:0] TB_SEEDS =
      {12'h000, 12'h001, 12'h5C3, 12'h000, 12'hA64};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [SW-1:0] step_count = '0;
   logic [RW-1:0] cut_resp = '0, gold_resp = '0;
   logic [11:0]   pat_state;
   logic [3:0]    pat_vec;
   logic          pat_valid, lfsr_active, done, mismatch;

   int checks = 0, errors = 0;
   int m_ph = 0, m_idx = 0, m_cnt = 0, m_rc = 0, m_mm = 0;
   logic [11:0] m_reg = '0;
   int mode = 0;

   always #2 clk = ~clk;

   rsd_pattern_gen #(
      .NUM_SEEDS(NS), .STEP_W(SW), .RESP_W(RW), .SEED_TABLE(TB_SEEDS)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .step_count(step_count),
      .cut_resp(cut_resp), .gold_resp(gold_resp), .pat_state(pat_state),
      .pat_vec(pat_vec), .pat_valid(pat_valid), .lfsr_active(lfsr_active),
      .done(done), .mismatch(mismatch)
   );

   function automatic logic [11:0] seed_of(int k);
      return TB_SEEDS[k*12 +: 12];
   endfunction
   function automatic logic [11:0] f_step(logic [11:0] s);
      return {s[10:0], s[11]^s[5]^s[3]^s[0]};
   endfunction
   function automatic logic [11:0] f_rotr(logic [11:0] s);
      return {s[0], s[11:1]};
   endfunction
   function automatic logic [3:0] f_shape(logic [11:0] s);
      return {s[9], s[6]&s[7], s[3], s[0]|s[1]};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // phases: 0 idle, 1 load, 2 run, 3 rot, 4 done
   task automatic compare();
      bit mv = (m_ph == 2 || m_ph == 3);
      chk(pat_valid == mv, "R5 pat_valid", pat_valid, mv);
      chk(lfsr_active == (m_ph == 2), "R3 lfsr_active", lfsr_active, m_ph == 2);
      chk(done == (m_ph == 4), "R8 done", done, m_ph == 4);
      chk(mismatch == m_mm[0], "R9 mismatch", mismatch, m_mm);
      if (mv) begin
         if (m_ph == 2 && m_cnt == 0)
            chk(pat_state == m_reg, "R2 first pattern is seed", pat_state, m_reg);
         else if (m_ph == 2)
            chk(pat_state == m_reg, "R3 advance pattern", pat_state, m_reg);
         else if (m_rc == 0 && step_count == 0)
            chk(pat_state == m_reg, "R10 zero steps rotate seed", pat_state, m_reg);
         else
            chk(pat_state == m_reg, "R4 rotate pattern", pat_state, m_reg);
         chk(pat_vec[1:0] == f_shape(m_reg)[1:0], "R6 vec bits 1:0", pat_vec, f_shape(m_reg));
         chk(pat_vec[3:2] == f_shape(m_reg)[3:2], "R7 vec bits 3:2", pat_vec, f_shape(m_reg));
      end
   endtask

   task automatic cyc(input bit st);
      bit mv = (m_ph == 2 || m_ph == 3);
      logic [RW-1:0] a, g;
      g = RW'($urandom);
      a = g;
      if (mode == 0 && ($urandom % 6) == 0) a = ~g;
      if (mode == 1 && !mv) a = ~g;
      start = st; cut_resp = a; gold_resp = g;
      @(posedge clk);
      if (st) m_mm = 0;
      else if (mv && a != g) m_mm = 1;
      if (st) begin
         m_ph = 1; m_idx = 0;
      end else begin
         case (m_ph)
            1: if (seed_of(m_idx) == 0) begin
                  if (m_idx == NS-1) m_ph = 4; else m_idx++;
               end else begin
                  m_reg = seed_of(m_idx); m_cnt = 0; m_rc = 0;
                  m_ph = (step_count == 0) ? 3 : 2;
               end
            2: begin
                  m_reg = f_step(m_reg); m_cnt++;
                  if (m_cnt >= step_count) begin m_ph = 3; m_rc = 0; end
               end
            3: begin
                  m_reg = f_rotr(m_reg); m_rc++;
                  if (m_rc == 11) begin
                     if (m_idx == NS-1) m_ph = 4;
                     else begin m_ph = 1; m_idx++; end
                  end
               end
            default: ;
         endcase
      end
      @(negedge clk);
      start = 1'b0;
      compare();
   endtask

   task automatic run_walk(input int sc, input int md, input int restart_at);
      mode = md;
      step_count = SW'(sc);
      cyc(1'b1);
      for (int n = 0; n < 2000 && m_ph != 4; n++) begin
         cyc(n == restart_at);
      end
      for (int n = 0; n < 3; n++) cyc(1'b0);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      compare();
      chk(mismatch == 1'b0 && done == 1'b0, "R1 in reset", {done, mismatch}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!pat_valid && !lfsr_active && !done && !mismatch, "R1 after reset",
          {pat_valid, lfsr_active, done, mismatch}, 0);
      cyc(1'b0);
      run_walk(5, 0, -1);
      run_walk(5, 1, -1);
      run_walk(0, 0, -1);
      run_walk(1, 0, 9);
      run_walk(63, 0, 40);
      for (int k = 0; k < 4; k++) run_walk(int'($urandom % 40), int'($urandom % 2), -1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule